// File: doc/BRIEF.md
# Two-Operand NaN Propagation Selector

This block produces the NaN result of a two-input binary64 operation when at least one operand is a NaN. Each operand is sorted into one of three groups: ordinary number (including infinities), quiet NaN or signaling NaN. Which NaN reaches the output is set by a policy select that offers four priority schemes. A policy either ranks signaling above quiet, ranks the first operand first, lets a use-first bit decide the order, or compares significand magnitudes with a sign tie-break. A signaling NaN that is chosen is quieted before it leaves the block. A default-NaN mode replaces the chosen value with the canonical NaN.

Which fraction MSB value marks a quiet NaN is set by a polarity input. Under the inverted polarity, quieting a chosen signaling NaN yields the canonical NaN and does not patch the operand. The invalid flag rises whenever either operand is signaling. This holds even when default-NaN mode decides the result. A pair that holds no NaN at all breaks the block's contract and is reported on a protocol-error output. Results are registered: one operand pair per input strobe, with the answer one clock later.

Top module: `nanprop_sel`

## Requirements
- R1: An operand is a NaN when its exponent field (bits 62:52) is all ones and its fraction (bits 51:0) is non-zero. With polarity input low, a NaN with fraction bit 51 set is quiet and one with it clear is signaling. An infinity (zero fraction) counts as an ordinary number.
- R2: The invalid flag is 1 exactly when either operand of the accepted pair is signaling, whatever the default-NaN mode.
- R3: Policy 0 returns the first match in this order: a if signaling, b if signaling, a if quiet, otherwise b.
- R4: Policy 1 returns a if a is any NaN, otherwise b.
- R5: Policy 2 with use-first high returns a if a is a NaN, else b. With use-first low it returns b if b is a NaN, else a.
- R6: Policy 3 returns the quiet operand when one signaling and one quiet NaN meet. A NaN paired with an ordinary number wins. When both NaNs are in the same group, the larger significand wins.
- R7: Policy 3 compares magnitudes as the 63 bits below the sign. On equal magnitudes the operand with sign 0 wins.
- R8: With polarity low, a chosen signaling NaN is output with fraction bit 51 set and all other bits unchanged. A chosen quiet NaN is output unchanged.
- R9: With polarity input high, fraction bit 51 set marks a signaling NaN and clear marks a quiet NaN. A chosen signaling NaN is then output as 0x7FF7FFFFFFFFFFFF.
- R10: With default-NaN mode set, the result is 0x7FF8000000000000 when polarity is low and 0x7FF7FFFFFFFFFFFF when polarity is high.
- R11: A pair accepted with inValid high gives outValid high one clock later, together with its result and flags. Without a strobe, outValid is low, the flags are low and the result holds its previous value.
- R12: An accepted pair with no NaN sets protocolErr with its result and leaves the invalid flag low. Any pair holding a NaN leaves protocolErr low.
- R13: During and after reset, outValid, invalidFlag, protocolErr and result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand pair strobe |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| policySel | input | 2 | Propagation policy 0..3 |
| useFirst | input | 1 | Order bit for policy 2 |
| defaultNanMode | input | 1 | Force canonical NaN result |
| snanPolarityInv | input | 1 | 1: fraction MSB set marks signaling |
| outValid | output | 1 | Result strobe |
| result | output | 64 | Propagated NaN |
| invalidFlag | output | 1 | A signaling operand was seen |
| protocolErr | output | 1 | Pair contained no NaN |

## Verification
The hardest case is the magnitude policy's sign tie-break. It only takes effect when both operands are NaNs of the same group whose lower 63 bits match exactly and whose signs differ. The bench builds that pair directly and then swaps the operands. The positive NaN must win from either position, which tells a true tie-break apart from a fixed operand preference. A second hard corner is invalid raised under default-NaN mode, because the forced result hides which operand was signaling. Only the flag shows it, so the bench pairs signaling and quiet inputs there under both polarities.

// File: rtl/nanprop_pkg.sv
package nanprop_pkg;

  typedef enum logic [1:0] {
    CLS_NUM  = 2'd0,
    CLS_QNAN = 2'd1,
    CLS_SNAN = 2'd2
  } opClass_e;

  typedef enum logic [1:0] {
    POL_SIG_FIRST = 2'd0,
    POL_A_FIRST   = 2'd1,
    POL_ORDERED   = 2'd2,
    POL_MAGNITUDE = 2'd3
  } policy_e;

  // datapath -> control: operand facts
  typedef struct packed {
    opClass_e clsA;
    opClass_e clsB;
    logic     aLarger;
  } opInfo_t;

  // control -> datapath: selection strobes
  typedef struct packed {
    logic pickB;
    logic silence;
    logic useDefault;
  } selStrobe_t;

endpackage

// File: rtl/nanprop_classify.sv
module nanprop_classify
  import nanprop_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] operand,
  input  logic         polInv,
  output opClass_e     cls
);

  logic expAll;
  logic fracNz;
  logic quietBit;

  assign expAll   = &operand[W-2:FRAC_W];
  assign fracNz   = |operand[FRAC_W-1:0];
  assign quietBit = operand[FRAC_W-1] ^ polInv;

  always_comb begin
    if (!expAll || !fracNz) cls = CLS_NUM;
    else if (quietBit)      cls = CLS_QNAN;
    else                    cls = CLS_SNAN;
  end

endmodule

// File: rtl/nanprop_datapath.sv
module nanprop_datapath
  import nanprop_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int NOPS  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         polInv,
  input  selStrobe_t   strobe,
  output opInfo_t      info,
  output logic [W-1:0] result
);

  logic [W-1:0] ops [NOPS];
  opClass_e     cls [NOPS];

  assign ops[0] = opA;
  assign ops[1] = opB;

  for (genvar i = 0; i < NOPS; i++) begin : g_cls
    nanprop_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .operand(ops[i]),
      .polInv (polInv),
      .cls    (cls[i])
    );
  end

  // magnitude ordering with sign tie-break (positive wins on equality)
  logic [W-2:0] magA, magB;
  logic         aLarger;
  assign magA    = opA[W-2:0];
  assign magB    = opB[W-2:0];
  assign aLarger = (magA > magB) || ((magA == magB) && (opA < opB));

  assign info = '{clsA: cls[0], clsB: cls[1], aLarger: aLarger};

  // canonical NaN for the current polarity
  logic [W-1:0] defNan;
  assign defNan = {1'b0, {EXP_W{1'b1}}, ~polInv, {(FRAC_W-1){polInv}}};

  logic [W-1:0] chosen;
  logic [W-1:0] nextResult;
  logic [W-1:0] quietMask;

  assign chosen    = strobe.pickB ? opB : opA;
  assign quietMask = {{(EXP_W+1){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

  always_comb begin
    if (strobe.useDefault || (strobe.silence && polInv))
      nextResult = defNan;
    else if (strobe.silence)
      nextResult = chosen | quietMask;
    else
      nextResult = chosen;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       result <= '0;
    else if (inValid) result <= nextResult;
  end

  // result signaling-check under previous polarity
  logic resIsNan;
  logic resQuietBit;
  logic pastPol;
  always_ff @(posedge clk) begin
    if (!rst_n) pastPol <= 1'b0;
    else        pastPol <= polInv;
  end
  assign resIsNan    = (&result[W-2:FRAC_W]) && (|result[FRAC_W-1:0]);
  assign resQuietBit = result[FRAC_W-1] ^ pastPol;

  p_result_quiet_nan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && ((cls[0] != CLS_NUM) || (cls[1] != CLS_NUM)))
      |=> (resIsNan && resQuietBit));

  p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable(result));

  p_default_nan_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && strobe.useDefault) |=> (result == $past(defNan)));

endmodule

// File: rtl/nanprop_ctrl.sv
module nanprop_ctrl
  import nanprop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic [1:0] policySel,
  input  logic       useFirst,
  input  logic       defaultNanMode,
  input  opInfo_t    info,
  output selStrobe_t strobe,
  output logic       outValid,
  output logic       invalidFlag,
  output logic       protocolErr
);

  logic aS, aQ, aN, bS, bQ, bN;
  assign aS = (info.clsA == CLS_SNAN);
  assign aQ = (info.clsA == CLS_QNAN);
  assign aN = aS || aQ;
  assign bS = (info.clsB == CLS_SNAN);
  assign bQ = (info.clsB == CLS_QNAN);
  assign bN = bS || bQ;

  logic pickB;

  always_comb begin
    pickB = 1'b0;
    case (policy_e'(policySel))
      POL_SIG_FIRST: begin
        if (aS)      pickB = 1'b0;
        else if (bS) pickB = 1'b1;
        else if (aQ) pickB = 1'b0;
        else         pickB = 1'b1;
      end
      POL_A_FIRST: pickB = !aN;
      POL_ORDERED: begin
        if (useFirst) pickB = !aN;
        else          pickB = bN;
      end
      POL_MAGNITUDE: begin
        if (aS) begin
          if (bS)      pickB = !info.aLarger;
          else         pickB = bQ;
        end else if (aQ) begin
          if (bQ)      pickB = !info.aLarger;
          else         pickB = 1'b0;
        end else begin
          pickB = 1'b1;
        end
      end
      default: pickB = 1'b0;
    endcase
  end

  assign strobe = '{pickB: pickB,
                    silence: pickB ? bS : aS,
                    useDefault: defaultNanMode};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid    <= 1'b0;
      invalidFlag <= 1'b0;
      protocolErr <= 1'b0;
    end else begin
      outValid    <= inValid;
      invalidFlag <= inValid && (aS || bS);
      protocolErr <= inValid && !aN && !bN;
    end
  end

  p_strobe_to_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  p_flags_need_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> (!invalidFlag && !protocolErr));

  p_invalid_on_snan_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && ((info.clsA == CLS_SNAN) || (info.clsB == CLS_SNAN))) |=> invalidFlag);

  p_no_nan_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && (info.clsA == CLS_NUM) && (info.clsB == CLS_NUM))
      |=> (protocolErr && !invalidFlag));

endmodule

// File: rtl/nanprop_sel.sv
module nanprop_sel
  import nanprop_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [1:0]   policySel,
  input  logic         useFirst,
  input  logic         defaultNanMode,
  input  logic         snanPolarityInv,
  output logic         outValid,
  output logic [W-1:0] result,
  output logic         invalidFlag,
  output logic         protocolErr
);

  opInfo_t    info;
  selStrobe_t strobe;

  nanprop_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .inValid(inValid),
    .opA    (opA),
    .opB    (opB),
    .polInv (snanPolarityInv),
    .strobe (strobe),
    .info   (info),
    .result (result)
  );

  nanprop_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .inValid       (inValid),
    .policySel     (policySel),
    .useFirst      (useFirst),
    .defaultNanMode(defaultNanMode),
    .info          (info),
    .strobe        (strobe),
    .outValid      (outValid),
    .invalidFlag   (invalidFlag),
    .protocolErr   (protocolErr)
  );

endmodule

// File: tb/nanprop_sel_bench.sv
`timescale 1ns/1ps
module nanprop_sel_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] opA = '0, opB = '0;
  logic [1:0]  policySel = '0;
  logic        useFirst = 1'b0, defaultNanMode = 1'b0, snanPolarityInv = 1'b0;
  logic        outValid, invalidFlag, protocolErr;
  logic [63:0] result;

  int testsRun = 0;
  int testsFailed = 0;

  always #2.5 clk = ~clk;

  nanprop_sel u_nanprop_sel (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opA(opA), .opB(opB),
    .policySel(policySel), .useFirst(useFirst), .defaultNanMode(defaultNanMode),
    .snanPolarityInv(snanPolarityInv), .outValid(outValid), .result(result),
    .invalidFlag(invalidFlag), .protocolErr(protocolErr)
  );

  localparam logic [63:0] QA   = 64'h7FF8_0000_0000_0001;
  localparam logic [63:0] QB   = 64'hFFF8_0000_0000_0002;
  localparam logic [63:0] SA   = 64'h7FF0_0000_0000_0005;
  localparam logic [63:0] SB   = 64'h7FF0_0000_0000_0009;
  localparam logic [63:0] SA_Q = 64'h7FF8_0000_0000_0005;
  localparam logic [63:0] SB_Q = 64'h7FF8_0000_0000_0009;
  localparam logic [63:0] NUM  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] INF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] DEF  = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] DEFI = 64'h7FF7_FFFF_FFFF_FFFF;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one pair at negedge, sample one clock later at negedge
  task automatic run(input string tag, input logic [63:0] a, input logic [63:0] b,
                     input logic [1:0] pol, input logic uf, input logic dflt,
                     input logic inv, input logic [63:0] expRes, input logic expInv,
                     input logic expErr);
    @(negedge clk);
    opA = a; opB = b; policySel = pol; useFirst = uf;
    defaultNanMode = dflt; snanPolarityInv = inv; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " outValid R11"}, {63'd0, outValid}, 64'd1);
    if (!expErr) check({tag, " result"}, result, expRes);
    check({tag, " invalid R2"}, {63'd0, invalidFlag}, {63'd0, expInv});
    check({tag, " protoErr R12"}, {63'd0, protocolErr}, {63'd0, expErr});
  endtask

  task automatic t_reset;
    check("R13 outValid", {63'd0, outValid}, 64'd0);
    check("R13 result", result, 64'd0);
    check("R13 invalid", {63'd0, invalidFlag}, 64'd0);
    check("R13 protoErr", {63'd0, protocolErr}, 64'd0);
  endtask

  task automatic t_policy0;
    run("R3 sA sB", SA, SB, 2'd0, 0, 0, 0, SA_Q, 1, 0);
    run("R3 qA sB", QA, SB, 2'd0, 0, 0, 0, SB_Q, 1, 0);
    run("R3 qA qB", QA, QB, 2'd0, 0, 0, 0, QA, 0, 0);
    run("R3 num qB", NUM, QB, 2'd0, 0, 0, 0, QB, 0, 0);
  endtask

  task automatic t_policy1;
    run("R4 num sB", NUM, SB, 2'd1, 0, 0, 0, SB_Q, 1, 0);
    run("R4 qA sB", QA, SB, 2'd1, 0, 0, 0, QA, 1, 0);
    run("R4 sA qB", SA, QB, 2'd1, 0, 0, 0, SA_Q, 1, 0);
    run("R1 inf qB", INF, QB, 2'd1, 0, 0, 0, QB, 0, 0);
  endtask

  task automatic t_policy2;
    run("R5 uf1 qA qB", QA, QB, 2'd2, 1, 0, 0, QA, 0, 0);
    run("R5 uf0 qA qB", QA, QB, 2'd2, 0, 0, 0, QB, 0, 0);
    run("R5 uf0 qA num", QA, NUM, 2'd2, 0, 0, 0, QA, 0, 0);
    run("R5 uf1 num sB", NUM, SB, 2'd2, 1, 0, 0, SB_Q, 1, 0);
  endtask

  task automatic t_policy3;
    run("R6 sA qB", SA, QB, 2'd3, 0, 0, 0, QB, 1, 0);
    run("R6 qA sB", QA, SB, 2'd3, 0, 0, 0, QA, 1, 0);
    run("R6 sA sB larger", SA, SB, 2'd3, 0, 0, 0, SB_Q, 1, 0);
    run("R6 qA qB larger", QA, QB, 2'd3, 0, 0, 0, QB, 0, 0);
    run("R6 num sA", NUM, SA, 2'd3, 0, 0, 0, SA_Q, 1, 0);
  endtask

  task automatic t_tiebreak;
    run("R7 neg a pos b", 64'hFFF8_0000_0000_0001, 64'h7FF8_0000_0000_0001, 2'd3, 0, 0, 0,
        64'h7FF8_0000_0000_0001, 0, 0);
    run("R7 pos a neg b", 64'h7FF8_0000_0000_0001, 64'hFFF8_0000_0000_0001, 2'd3, 0, 0, 0,
        64'h7FF8_0000_0000_0001, 0, 0);
  endtask

  task automatic t_silence;
    run("R8 neg snan", 64'hFFF0_0000_0000_0123, NUM, 2'd0, 0, 0, 0,
        64'hFFF8_0000_0000_0123, 1, 0);
  endtask

  task automatic t_inverted;
    run("R9 inv snan a", 64'h7FF8_0000_0000_0001, SB, 2'd0, 0, 0, 1, DEFI, 1, 0);
    run("R9 inv quiet pair", SA, SB, 2'd0, 0, 0, 1, SA, 0, 0);
  endtask

  task automatic t_default;
    run("R10 dflt sA qB", SA, QB, 2'd0, 0, 1, 0, DEF, 1, 0);
    run("R10 dflt qA num", QA, NUM, 2'd1, 0, 1, 0, DEF, 0, 0);
    run("R10 dflt inv", NUM, SA, 2'd3, 0, 1, 1, DEFI, 0, 0);
    run("R10 dflt inv snan", 64'h7FF8_0000_0000_0001, NUM, 2'd1, 0, 1, 1, DEFI, 1, 0);
  endtask

  task automatic t_protocol;
    run("R12 num num", NUM, NUM, 2'd0, 0, 0, 0, 64'd0, 0, 1);
    run("R12 inf num", INF, NUM, 2'd3, 0, 0, 0, 64'd0, 0, 1);
  endtask

  task automatic t_hold;
    logic [63:0] last;
    run("R11 setup", QA, QB, 2'd0, 0, 0, 0, QA, 0, 0);
    last = result;
    opA = SA; opB = SB;
    repeat (3) @(negedge clk);
    check("R11 idle outValid", {63'd0, outValid}, 64'd0);
    check("R11 idle result hold", result, last);
    check("R11 idle invalid", {63'd0, invalidFlag}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_policy0();
    t_policy1();
    t_policy2();
    t_policy3();
    t_tiebreak();
    t_silence();
    t_inverted();
    t_default();
    t_protocol();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule